// File: doc/BRIEF.md
# Shared-Pin Memory Bus Arbiter

This block lets several off-chip memory controllers on one clock domain take turns on a single set of address, write-data, data-enable, read and write pins. Each controller port raises a request and waits for its grant. Once granted, it owns the shared bus for as long as it keeps its request high, so a multi-word access can run without a break. When several ports ask at the same time, a rotating priority picks the next owner.

Ports may be narrower than the shared bus. A narrow port's address and data are placed from bit 0 upward, and the bits above its width read as zero on the shared bus. Data coming back from the pins reaches every port, masked to that port's own width. Chip selects and interrupt lines do not take part in arbitration. They connect straight through unchanged. The tristate buffers and pin timing sit outside this block.

Top module: `pin_share_arbiter`

## Requirements
- R1: At most one grant output is high in any cycle.
- R2: While rst_n is low (sampled on the rising clock edge), every grant is low and the shared address, write data, data-enable, read and write outputs are all zero.
- R3: A granted port keeps its grant on every following cycle for as long as its request stays high.
- R4: In the cycle after the owner is seen with its request low, no grant is high. A new owner can be chosen only from that idle state.
- R5: From the idle state, the grant goes to the first requesting port found in rising index order, starting just after the port that was granted last and wrapping around. After reset the search starts at port 0.
- R6: Grants are registered: a request sampled at a rising edge during the idle state shows up as a grant after that same edge.
- R7: The shared address and write data equal the owner's, with every bit at or above that port's own address or data width forced to zero. Default widths are address 12/10/12 and data 16/8/12 for ports 0/1/2.
- R8: The shared data-enable, read and write equal the owner's signals. They are all low when no port is granted.
- R9: Each port's read-data output equals the shared input data with the bits at or above that port's data width cleared.
- R10: Each port's chip select and interrupt pass through unchanged every cycle, whatever the grant state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all ports |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | NPORT | Per-port bus request |
| gnt_o | output | NPORT | Per-port grant |
| p_addr_i | input | NPORT x AW | Per-port address |
| p_wdata_i | input | NPORT x DW | Per-port write data |
| p_wdata_oe_i | input | NPORT | Per-port data output-enable |
| p_rd_i | input | NPORT | Per-port read strobe |
| p_wr_i | input | NPORT | Per-port write strobe |
| p_rdata_o | output | NPORT x DW | Per-port returned data, masked to port width |
| p_csel_i | input | NPORT | Per-port chip select (not shared) |
| pin_csel_o | output | NPORT | Chip selects toward the pins |
| pin_irq_i | input | NPORT | Interrupt lines from the pins |
| p_irq_o | output | NPORT | Interrupts toward each port |
| bus_addr_o | output | AW | Shared address |
| bus_wdata_o | output | DW | Shared write data |
| bus_oe_o | output | 1 | Shared data output-enable |
| bus_rd_o | output | 1 | Shared read strobe |
| bus_wr_o | output | 1 | Shared write strobe |
| bus_rdata_i | input | DW | Shared input data from the pins |

## Verification
The assertions check the following on every cycle: the grant stays one-hot or empty, a held request keeps its grant, a dropped request leads to an empty grant, an idle cycle with requests leads to a grant that one of those requesters asked for, and a narrow owner leaves the upper bus bits at zero. Only the bench's reference model can show which requester wins under the rotating order, that the shared pins carry exactly the owner's values, and that returned data and the pass-through lines are correct for every port. The bench covers a lone requester, all ports asking at once, staggered releases and long random traffic with reset asserted mid-run.

// File: rtl/pshare_pkg.sv
// Shared helpers for the pin-sharing arbiter.
// Assumes all widths are small positive integers.
package pshare_pkg;

    // True when bit position bit_pos lies inside a field of the given width.
    function automatic logic lane_kept(input int unsigned bit_pos, input int unsigned width);
        return (bit_pos < width) ? 1'b1 : 1'b0;
    endfunction

endpackage

// File: rtl/pshare_arb.sv
// Rotating-priority arbiter with ownership held while the request stays high.
// The owner keeps its grant while its request is high. A dropped request
// releases the bus for one cycle. A new winner is picked only from idle,
// with the search starting after the previous winner.
// Assumes NPORT >= 2 and a single clock domain.
module pshare_arb #(
    parameter int NPORT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] req_i,
    output logic [NPORT-1:0] gnt_o
);
    localparam int IDXW = (NPORT > 1) ? $clog2(NPORT) : 1;

    logic [NPORT-1:0] gnt_q, gnt_d, pick;
    logic [IDXW-1:0]  last_q, last_d, pick_idx;
    logic             found;

    // Search requesters in rotating order, starting after the last winner.
    always_comb begin
        pick     = '0;
        pick_idx = last_q;
        found    = 1'b0;
        for (int k = 1; k <= NPORT; k++) begin
            int idx;
            idx = int'(last_q) + k;
            if (idx >= NPORT) idx = idx - NPORT;
            if (!found && req_i[IDXW'(idx)]) begin
                found              = 1'b1;
                pick[IDXW'(idx)]   = 1'b1;
                pick_idx           = IDXW'(idx);
            end
        end
    end

    // Next grant: hold, release for one cycle, or pick from idle.
    always_comb begin
        last_d = last_q;
        if (|gnt_q) begin
            gnt_d = (|(req_i & gnt_q)) ? gnt_q : '0;
        end else begin
            gnt_d = pick;
            if (found) last_d = pick_idx;
        end
    end

    // Grant and priority pointer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_q  <= '0;
            last_q <= IDXW'(NPORT - 1);
        end else begin
            gnt_q  <= gnt_d;
            last_q <= last_d;
        end
    end

    assign gnt_o = gnt_q;

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o)); // R1
    AST_HOLD_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        ((|gnt_o) && (|(req_i & gnt_o))) |=> (gnt_o == $past(gnt_o))); // R3
    AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((|gnt_o) && !(|(req_i & gnt_o))) |=> (gnt_o == '0)); // R4
    AST_GRANT_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_o == '0) && (|req_i)) |=> ($onehot(gnt_o) && (|(gnt_o & $past(req_i))))); // R6

endmodule

// File: rtl/pshare_mux.sv
// Shared-bus multiplexer with zero-extension from bit 0.
// Masks each port's address and data to that port's width, then builds an
// AND-OR select on the one-hot grant. With no grant every shared output is
// zero. Returned data goes to every port, masked to the port's width.
// Assumes the grant is one-hot or empty and each port width <= bus width.
module pshare_mux
    import pshare_pkg::*;
#(
    parameter int          NPORT = 3,
    parameter int          AW    = 12,
    parameter int          DW    = 16,
    parameter int unsigned PORT_AW [NPORT] = '{12, 10, 12},
    parameter int unsigned PORT_DW [NPORT] = '{16, 8, 12}
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NPORT-1:0]          gnt_i,
    input  logic [NPORT-1:0][AW-1:0]  p_addr_i,
    input  logic [NPORT-1:0][DW-1:0]  p_wdata_i,
    input  logic [NPORT-1:0]          p_oe_i,
    input  logic [NPORT-1:0]          p_rd_i,
    input  logic [NPORT-1:0]          p_wr_i,
    output logic [NPORT-1:0][DW-1:0]  p_rdata_o,
    output logic [AW-1:0]             bus_addr_o,
    output logic [DW-1:0]             bus_wdata_o,
    output logic                      bus_oe_o,
    output logic                      bus_rd_o,
    output logic                      bus_wr_o,
    input  logic [DW-1:0]             bus_rdata_i
);
    logic [NPORT-1:0][AW-1:0] akeep, addr_m;
    logic [NPORT-1:0][DW-1:0] dkeep, wdata_m;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        for (genvar b = 0; b < AW; b++) begin : g_abit
            assign akeep[p][b] = lane_kept(b, PORT_AW[p]);
        end
        for (genvar b = 0; b < DW; b++) begin : g_dbit
            assign dkeep[p][b] = lane_kept(b, PORT_DW[p]);
        end
        assign addr_m[p]    = p_addr_i[p] & akeep[p];
        assign wdata_m[p]   = p_wdata_i[p] & dkeep[p];
        assign p_rdata_o[p] = bus_rdata_i & dkeep[p];

        AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_i[p] |-> (((bus_wdata_o & ~dkeep[p]) == '0)
                          && ((bus_addr_o & ~akeep[p]) == '0))); // R7
    end

    // AND-OR select of the owner's signals onto the shared bus.
    always_comb begin
        bus_addr_o  = '0;
        bus_wdata_o = '0;
        bus_oe_o    = 1'b0;
        bus_rd_o    = 1'b0;
        bus_wr_o    = 1'b0;
        for (int p = 0; p < NPORT; p++) begin
            if (gnt_i[p]) begin
                bus_addr_o  = bus_addr_o  | addr_m[p];
                bus_wdata_o = bus_wdata_o | wdata_m[p];
                bus_oe_o    = bus_oe_o    | p_oe_i[p];
                bus_rd_o    = bus_rd_o    | p_rd_i[p];
                bus_wr_o    = bus_wr_o    | p_wr_i[p];
            end
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_i == '0) |-> (!bus_oe_o && !bus_rd_o && !bus_wr_o)); // R8

endmodule

// File: rtl/pin_share_arbiter.sv
// Top level of the shared-pin memory bus arbiter.
// Joins the rotating arbiter and the width-aligning multiplexer. Chip
// selects and interrupts pass straight through without arbitration.
// Assumes every port runs on clk and rst_n is synchronous, active low.
module pin_share_arbiter #(
    parameter int          NPORT = 3,
    parameter int          AW    = 12,
    parameter int          DW    = 16,
    parameter int unsigned PORT_AW [NPORT] = '{12, 10, 12},
    parameter int unsigned PORT_DW [NPORT] = '{16, 8, 12}
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NPORT-1:0]          req_i,
    output logic [NPORT-1:0]          gnt_o,
    input  logic [NPORT-1:0][AW-1:0]  p_addr_i,
    input  logic [NPORT-1:0][DW-1:0]  p_wdata_i,
    input  logic [NPORT-1:0]          p_wdata_oe_i,
    input  logic [NPORT-1:0]          p_rd_i,
    input  logic [NPORT-1:0]          p_wr_i,
    output logic [NPORT-1:0][DW-1:0]  p_rdata_o,
    input  logic [NPORT-1:0]          p_csel_i,
    output logic [NPORT-1:0]          pin_csel_o,
    input  logic [NPORT-1:0]          pin_irq_i,
    output logic [NPORT-1:0]          p_irq_o,
    output logic [AW-1:0]             bus_addr_o,
    output logic [DW-1:0]             bus_wdata_o,
    output logic                      bus_oe_o,
    output logic                      bus_rd_o,
    output logic                      bus_wr_o,
    input  logic [DW-1:0]             bus_rdata_i
);
    logic [NPORT-1:0] gnt;

    pshare_arb #(.NPORT(NPORT)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req_i),
        .gnt_o (gnt)
    );

    pshare_mux #(
        .NPORT   (NPORT),
        .AW      (AW),
        .DW      (DW),
        .PORT_AW (PORT_AW),
        .PORT_DW (PORT_DW)
    ) u_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .gnt_i       (gnt),
        .p_addr_i    (p_addr_i),
        .p_wdata_i   (p_wdata_i),
        .p_oe_i      (p_wdata_oe_i),
        .p_rd_i      (p_rd_i),
        .p_wr_i      (p_wr_i),
        .p_rdata_o   (p_rdata_o),
        .bus_addr_o  (bus_addr_o),
        .bus_wdata_o (bus_wdata_o),
        .bus_oe_o    (bus_oe_o),
        .bus_rd_o    (bus_rd_o),
        .bus_wr_o    (bus_wr_o),
        .bus_rdata_i (bus_rdata_i)
    );

    assign gnt_o      = gnt;
    assign pin_csel_o = p_csel_i;   // R10: unshared, no arbitration
    assign p_irq_o    = pin_irq_i;  // R10: unshared, no arbitration

endmodule

// File: tb/pin_share_arbiter_bench.sv
// Bench: a behavioural reference model, compared with the outputs on every clock.
module pin_share_arbiter_bench;
    localparam int NP = 3;
    localparam int AW = 12;
    localparam int DW = 16;
    localparam int AWS [NP] = '{12, 10, 12};
    localparam int DWS [NP] = '{16, 8, 12};

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [NP-1:0]          req = '0;
    logic [NP-1:0]          gnt;
    logic [NP-1:0][AW-1:0]  p_addr = '0;
    logic [NP-1:0][DW-1:0]  p_wdata = '0;
    logic [NP-1:0]          p_oe = '0, p_rd = '0, p_wr = '0;
    logic [NP-1:0][DW-1:0]  p_rdata;
    logic [NP-1:0]          csel_in = '0, csel_out, irq_in = '0, irq_out;
    logic [AW-1:0]          b_addr;
    logic [DW-1:0]          b_wdata;
    logic                   b_oe, b_rd, b_wr;
    logic [DW-1:0]          b_rdata = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int owner    = -1;
    int last     = NP - 1;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pin_share_arbiter u_pin_share_arbiter (
        .clk(clk), .rst_n(rst_n), .req_i(req), .gnt_o(gnt),
        .p_addr_i(p_addr), .p_wdata_i(p_wdata), .p_wdata_oe_i(p_oe),
        .p_rd_i(p_rd), .p_wr_i(p_wr), .p_rdata_o(p_rdata),
        .p_csel_i(csel_in), .pin_csel_o(csel_out),
        .pin_irq_i(irq_in), .p_irq_o(irq_out),
        .bus_addr_o(b_addr), .bus_wdata_o(b_wdata), .bus_oe_o(b_oe),
        .bus_rd_o(b_rd), .bus_wr_o(b_wr), .bus_rdata_i(b_rdata)
    );

    function automatic logic [63:0] lowbits(input logic [63:0] v, input int w);
        logic [63:0] r;
        r = '0;
        for (int b = 0; b < w; b++) r[b] = v[b];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    // Reference model: advance at the edge, compare 2 ns later.
    always @(posedge clk) begin
        if (!rst_n) begin
            owner = -1;
            last  = NP - 1;
        end else if (owner >= 0) begin
            if (!req[owner]) owner = -1;
        end else begin
            for (int k = 1; k <= NP; k++) begin
                int idx;
                idx = (last + k) % NP;
                if (req[idx]) begin
                    owner = idx;
                    last  = idx;
                    break;
                end
            end
        end
        #2;
        begin
            logic [NP-1:0] eg;
            eg = '0;
            if (owner >= 0) eg[owner] = 1'b1;
            if (!rst_n) begin
                chk("R2 grant", 64'(gnt), 64'(eg));
                chk("R2 bus", {b_addr, b_wdata, b_oe, b_rd, b_wr}, '0);
            end else begin
                chk("R1/R3/R4/R5/R6 grant", 64'(gnt), 64'(eg));
                chk("R7 addr", 64'(b_addr),
                    owner >= 0 ? lowbits(64'(p_addr[owner]), AWS[owner]) : 64'd0);
                chk("R7 wdata", 64'(b_wdata),
                    owner >= 0 ? lowbits(64'(p_wdata[owner]), DWS[owner]) : 64'd0);
                chk("R8 oe/rd/wr", {61'd0, b_oe, b_rd, b_wr},
                    owner >= 0 ? {61'd0, p_oe[owner], p_rd[owner], p_wr[owner]} : 64'd0);
            end
            for (int i = 0; i < NP; i++)
                chk("R9 rdata", 64'(p_rdata[i]), lowbits(64'(b_rdata), DWS[i]));
            chk("R10 csel", 64'(csel_out), 64'(csel_in));
            chk("R10 irq", 64'(irq_out), 64'(irq_in));
        end
    end

    task automatic scramble();
        for (int i = 0; i < NP; i++) begin
            p_addr[i]  = AW'($urandom);
            p_wdata[i] = DW'($urandom);
        end
        p_oe    = NP'($urandom);
        p_rd    = NP'($urandom);
        p_wr    = NP'($urandom);
        csel_in = NP'($urandom);
        irq_in  = NP'($urandom);
        b_rdata = DW'($urandom);
    endtask

    task automatic step(input logic [NP-1:0] r, input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            req = r;
            scramble();
        end
    endtask

    initial begin
        // R2: reset with requests and data driven
        step('1, 3);
        @(negedge clk) rst_n = 1'b1;
        // R5, R3, R4: port 1 alone, held, then dropped
        step(3'b010, 5);
        step(3'b000, 3);
        // R5: all ask, each owner holds then releases in turn
        step(3'b111, 4);
        step(3'b101, 3);
        step(3'b111, 6);
        step(3'b011, 4);
        step(3'b000, 2);
        // R7: narrow port 1 owns with full-width data driven
        step(3'b010, 4);
        step(3'b000, 1);
        // long random traffic with a mid-run reset
        for (int c = 0; c < 400; c++) begin
            step(NP'($urandom), 1 + ($urandom % 4));
            if (c == 200) begin
                @(negedge clk) rst_n = 1'b0;
                step('1, 2);
                @(negedge clk) rst_n = 1'b1;
            end
        end
        step(3'b000, 3);
        @(posedge clk);
        #5;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule